// File: doc/BRIEF.md
# Prescaled Capture/Compare Timer

This block is a 16-bit up-counting timer with a small synchronous register interface. A tick source is chosen from four options: off, the system clock, the system clock divided by 16, or falling edges of an external pin. That tick passes through an 8-bit programmable divider, and each divided tick advances the counter by one.

When an increment makes the counter equal a programmable reference value, the block records a reference event. It then either keeps counting or clears the counter, as software chooses. It also drives an output pin, either as a one-cycle low pulse or as a toggle.

The same external pin, after synchronisation, can latch the counter into a capture register on rising edges, on falling edges or on both. Both kinds of event are held in a write-one-to-clear flag register, and they combine into a single interrupt line. Software configures the block through a mode word and reads the counter, the capture value and the flags at fixed addresses.

Top module: `cct_timer`

## Requirements
- R1: The mode field `psc` (mode bits 15:8) divides the selected tick source by `psc`+1: 0x00 gives every source tick, and 0xFF gives one counter step per 256 source ticks.
- R2: The mode field `src` (mode bits 1:0) picks the tick source: 0 none, 1 every system clock, 2 one tick per 16 system clocks, 3 each falling edge of `ext_pin`.
- R3: While the mode bit `run` (bit 2) is 0, the counter and divider are held at zero from the next clock on, so a 1-to-0 change of `run` resets them. The mode and reference registers stay writable while `run` is 0.
- R4: The reference register resets to 0xFFFF. A reference event occurs when an increment makes the counter equal to it, and the event sets flag bit 1 of the event register.
- R5: If the mode bit `restart` (bit 3) is 1, a reference event clears the counter instead of loading the matching value. If it is 0, counting continues past the reference value.
- R6: `tmr_out` is high out of reset. With the mode bit `toggle` (bit 4) at 0, each reference event drives it low for exactly one clock cycle.
- R7: With `toggle` at 1, each reference event inverts `tmr_out`.
- R8: The mode field `cap` (bits 7:6) selects capture edges of the synchronised `ext_pin`: 0 none, 1 rising, 2 falling, 3 both. On a selected edge the counter value is copied into the capture register and flag bit 0 is set. Edges that are not selected have no effect.
- R9: Writing the event register (address 4) clears each flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R10: `irq` is high when the capture flag is set and `cap` is nonzero, or when the reference flag is set and the mode bit `ref_ie` (bit 5) is 1. It rises in the cycle after `ref_ie` is written with the reference flag already pending, and `ref_ie` has no effect on the capture term.
- R11: `ext_pin` passes through a two-stage synchroniser before edge detection. When it is the tick source, it is counted correctly with high and low phases as short as one clock.
- R12: The register map is: address 0 mode (read/write), 1 reference (read/write), 2 capture (read-only), 3 counter (read-only), 4 event flags. Other addresses read 0. Out of reset, mode, counter, capture and flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| ext_pin | input | 1 | External tick/capture input, asynchronous |
| tmr_out | output | 1 | Compare output (pulse or toggle) |
| irq | output | 1 | Interrupt request |

## Verification
Some relations between internal strobes and registered state are checked by assertions on every cycle:
- the pulse-mode output level follows the previous cycle's reference event;
- a reference event inverts the output in toggle mode;
- the counter clears or lands on the reference value, depending on `restart`;
- a stopped counter sits at zero;
- a capture strobe loads the counter value and raises its flag.

Other behaviour only the directed scenarios can show, because it depends on sequences of stimulus:
- exact divider ratios over long windows;
- the counting of external falling edges;
- the choice of capture edges;
- write-one-to-clear selectivity;
- the immediate interrupt when `ref_ie` is written with the flag already pending.

// File: rtl/cct_pkg.sv
// Package: shared constants and types for the capture/compare timer.
// Assumes a 16-bit register data path; the mode word layout is fixed here.
package cct_pkg;
    localparam int DATA_W = 16;
    localparam int PSC_W  = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_REF  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CAP  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_EVT  = 3'd4;

    localparam int EVT_CAP_BIT = 0;
    localparam int EVT_REF_BIT = 1;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SYS  = 2'd1,
        SRC_DIV  = 2'd2,
        SRC_PIN  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        CAP_OFF  = 2'd0,
        CAP_RISE = 2'd1,
        CAP_FALL = 2'd2,
        CAP_BOTH = 2'd3
    } cap_e;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        cap_e             cap;
        logic             ref_ie;
        logic             toggle;
        logic             restart;
        logic             run;
        src_e             src;
    } mode_t;
endpackage

// File: rtl/cct_sync_edge.sv
// Module: cct_sync_edge
// Brings an asynchronous pin into the clock domain through a chain of
// flops and reports single-cycle rising and falling strobes.
// Assumes the pin holds each level for at least one clock.
module cct_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic              level;

    // Shift the pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin};
    end

    assign level = chain_q[STAGES-1];

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;
endmodule

// File: rtl/cct_prescaler.sv
// Module: cct_prescaler
// Selects the raw tick source and divides it by psc+1. Emits one tick
// per divided period. Both dividers are held at zero while run is low.
// Assumes pin_fall is already a synchronised single-cycle strobe.
module cct_prescaler
    import cct_pkg::*;
#(
    parameter int DIV_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  src_e             src,
    input  logic [PSC_W-1:0] psc,
    input  logic             pin_fall,
    output logic             tick
);
    logic [DIV_LOG2-1:0] div_q;
    logic [PSC_W-1:0]    pcnt_q;
    logic                div_tick;
    logic                src_tick;

    // Fixed divide-by-2^DIV_LOG2 of the system clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) div_q <= '0;
        else                div_q <= div_q + DIV_LOG2'(1);
    end

    assign div_tick = run & (&div_q);

    // Pick the raw tick source.
    always_comb begin
        unique case (src)
            SRC_SYS:  src_tick = run;
            SRC_DIV:  src_tick = div_tick;
            SRC_PIN:  src_tick = run & pin_fall;
            default:  src_tick = 1'b0;
        endcase
    end

    // Programmable divide: tick when the count reaches psc, then restart.
    assign tick = src_tick & (pcnt_q >= psc);

    // Advance the programmable divider on each raw source tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pcnt_q <= '0;
        else if (tick)      pcnt_q <= '0;
        else if (src_tick)  pcnt_q <= pcnt_q + PSC_W'(1);
    end
endmodule

// File: rtl/cct_counter.sv
// Module: cct_counter
// Up-counter with reference compare. A hit is flagged when an increment
// would make the count equal the reference; restart then clears the count.
// Assumes tick is only high while run is high.
module cct_counter
    import cct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              restart,
    input  logic [DATA_W-1:0] ref_val,
    output logic [DATA_W-1:0] count,
    output logic              hit
);
    logic [DATA_W-1:0] nxt;

    assign nxt = count + DATA_W'(1);
    assign hit = tick & (nxt == ref_val);

    // Count divided ticks; clear on stop or on a restart hit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)      count <= '0;
        else if (hit && restart) count <= '0;
        else if (tick)           count <= nxt;
    end
endmodule

// File: rtl/cct_timer.sv
// Module: cct_timer (top)
// Prescaled 16-bit capture/compare timer with a register interface.
// Holds the mode, reference, capture and event registers. Drives the
// compare output and the interrupt. Assumes single-cycle write strobes
// and a combinational read port.
module cct_timer
    import cct_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_LOG2    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ext_pin,
    output logic              tmr_out,
    output logic              irq
);
    mode_t             mode_q;
    logic [DATA_W-1:0] ref_q;
    logic [DATA_W-1:0] cap_q;
    logic [DATA_W-1:0] count;
    logic              evt_cap_q;
    logic              evt_ref_q;
    logic              pin_rise;
    logic              pin_fall;
    logic              tick;
    logic              hit;
    logic              cap_ev;
    logic              md_run;
    logic              md_restart;
    logic              md_toggle;
    logic              wr_mode;
    logic              wr_ref;
    logic              wr_evt;

    assign md_run     = mode_q.run;
    assign md_restart = mode_q.restart;
    assign md_toggle  = mode_q.toggle;

    assign wr_mode = reg_wr && (reg_addr == ADR_MODE);
    assign wr_ref  = reg_wr && (reg_addr == ADR_REF);
    assign wr_evt  = reg_wr && (reg_addr == ADR_EVT);

    cct_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_pin),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    cct_prescaler #(
        .DIV_LOG2 (DIV_LOG2)
    ) i_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (md_run),
        .src      (mode_q.src),
        .psc      (mode_q.psc),
        .pin_fall (pin_fall),
        .tick     (tick)
    );

    cct_counter i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (md_run),
        .tick    (tick),
        .restart (md_restart),
        .ref_val (ref_q),
        .count   (count),
        .hit     (hit)
    );

    // Mode register: software-written configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (wr_mode) mode_q <= mode_t'(reg_wdata);
    end

    // Reference register: compare value, all ones out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      ref_q <= '1;
        else if (wr_ref) ref_q <= reg_wdata;
    end

    // Decode which synchronised pin edges trigger a capture.
    always_comb begin
        unique case (mode_q.cap)
            CAP_RISE: cap_ev = pin_rise;
            CAP_FALL: cap_ev = pin_fall;
            CAP_BOTH: cap_ev = pin_rise | pin_fall;
            default:  cap_ev = 1'b0;
        endcase
    end

    // Capture register: latch the counter on a selected edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_q <= '0;
        else if (cap_ev) cap_q <= count;
    end

    // Event flags: set by events, cleared by writing ones; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_cap_q <= 1'b0;
            evt_ref_q <= 1'b0;
        end else begin
            evt_cap_q <= cap_ev | (evt_cap_q & ~(wr_evt & reg_wdata[EVT_CAP_BIT]));
            evt_ref_q <= hit    | (evt_ref_q & ~(wr_evt & reg_wdata[EVT_REF_BIT]));
        end
    end

    // Compare output: one-cycle low pulse or toggle on each hit.
    always_ff @(posedge clk) begin
        if (!rst_n)          tmr_out <= 1'b1;
        else if (md_toggle)  tmr_out <= tmr_out ^ hit;
        else                 tmr_out <= ~hit;
    end

    // Interrupt: each flag gated by its own enable.
    assign irq = (evt_cap_q & (mode_q.cap != CAP_OFF)) | (evt_ref_q & mode_q.ref_ie);

    // Read multiplexer.
    always_comb begin
        unique case (reg_addr)
            ADR_MODE: reg_rdata = mode_q;
            ADR_REF:  reg_rdata = ref_q;
            ADR_CAP:  reg_rdata = cap_q;
            ADR_CNT:  reg_rdata = count;
            ADR_EVT:  reg_rdata = {{(DATA_W-2){1'b0}}, evt_ref_q, evt_cap_q};
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cct_timer_chk.sv
// Module: cct_timer_chk
// Concurrent checks on the timer's compare, count and capture paths,
// bound into every cct_timer instance.
module cct_timer_chk
    import cct_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              restart,
    input logic              toggle,
    input logic              hit,
    input logic              cap_ev,
    input logic              tmr_out,
    input logic              evt_cap,
    input logic              evt_ref,
    input logic [DATA_W-1:0] count,
    input logic [DATA_W-1:0] ref_val,
    input logic [DATA_W-1:0] cap_val
);
    assert_stopped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run) |-> (count == '0));

    assert_hit_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hit) |-> evt_ref);

    assert_restart_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hit && restart) |-> (count == '0));

    assert_freerun_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hit && !restart) |-> (count == $past(ref_val)));

    assert_pulse_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!toggle) |-> (tmr_out == !$past(hit)));

    assert_toggle_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hit && toggle) |-> (tmr_out != $past(tmr_out)));

    assert_capture_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cap_ev) |-> (cap_val == $past(count) && evt_cap));
endmodule

bind cct_timer cct_timer_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (md_run),
    .restart (md_restart),
    .toggle  (md_toggle),
    .hit     (hit),
    .cap_ev  (cap_ev),
    .tmr_out (tmr_out),
    .evt_cap (evt_cap_q),
    .evt_ref (evt_ref_q),
    .count   (count),
    .ref_val (ref_q),
    .cap_val (cap_q)
);

// File: tb/test_cct_timer.sv
module test_cct_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        ext_pin = 1'b0;
    logic        tmr_out;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cct_timer i_cct_timer (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .ext_pin (ext_pin),
        .tmr_out (tmr_out), .irq (irq)
    );

    function automatic logic [15:0] mw(input logic [7:0] psc, input logic [1:0] cap,
                                       input logic ie, input logic tog, input logic rs,
                                       input logic run, input logic [1:0] src);
        return {psc, cap, ie, tog, rs, run, src};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic delta(input string req, input logic [15:0] mode, input int cyc, input int exp);
        logic [15:0] c0, c1;
        wr(3'd0, 16'h0000);
        wr(3'd0, mode);
        repeat (3) @(negedge clk);
        rd(3'd3, c0);
        repeat (cyc) @(negedge clk);
        rd(3'd3, c1);
        check(req, c1 - c0, 16'(exp));
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(3'd0, v); check("R12 mode reset", v, 16'h0000);
        rd(3'd1, v); check("R4 ref reset", v, 16'hFFFF);
        rd(3'd2, v); check("R12 cap reset", v, 16'h0000);
        rd(3'd3, v); check("R12 cnt reset", v, 16'h0000);
        rd(3'd4, v); check("R12 evt reset", v, 16'h0000);
        rd(3'd6, v); check("R12 unmapped", v, 16'h0000);
        check("R6 out high at reset", {15'd0, tmr_out}, 16'd1);
        check("R10 irq reset", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_regs_while_stopped;
        logic [15:0] v;
        wr(3'd0, 16'h3BF9);
        rd(3'd0, v); check("R3 mode writable when stopped", v, 16'h3BF9);
        wr(3'd1, 16'h1234);
        rd(3'd1, v); check("R3 ref writable when stopped", v, 16'h1234);
        repeat (10) @(negedge clk);
        rd(3'd3, v); check("R3 counter idle when stopped", v, 16'h0000);
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'hFFFF);
    endtask

    task automatic t_sources;
        logic [15:0] v;
        wr(3'd0, mw(8'd0, 2'd0, 0, 0, 0, 1, 2'd1));
        repeat (10) @(negedge clk);
        rd(3'd3, v); check("R2 sys clock exact count", v, 16'd10);
        wr(3'd0, 16'h0000);
        repeat (2) @(negedge clk);
        rd(3'd3, v); check("R3 stop clears counter", v, 16'd0);
        repeat (10) @(negedge clk);
        rd(3'd3, v); check("R3 stays cleared", v, 16'd0);
        delta("R2 source none", mw(8'd0, 2'd0, 0, 0, 0, 1, 2'd0), 40, 0);
        delta("R1 psc 3 divides by 4", mw(8'd3, 2'd0, 0, 0, 0, 1, 2'd1), 40, 10);
        delta("R1 psc 0xFF divides by 256", mw(8'hFF, 2'd0, 0, 0, 0, 1, 2'd1), 512, 2);
        delta("R2 div16 source", mw(8'd0, 2'd0, 0, 0, 0, 1, 2'd2), 64, 4);
        delta("R1 R2 div16 with psc 1", mw(8'd1, 2'd0, 0, 0, 0, 1, 2'd2), 128, 4);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_compare;
        logic [15:0] v;
        int lows, dbl, flips, maxc;
        logic prev;
        wr(3'd4, 16'h0003);
        wr(3'd1, 16'd5);
        wr(3'd0, mw(8'd0, 2'd0, 0, 0, 1, 1, 2'd1));
        repeat (7) @(negedge clk);
        lows = 0; dbl = 0; maxc = 0; prev = 1'b1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            rd(3'd3, v);
            if (int'(v) > maxc) maxc = int'(v);
            if (!tmr_out) lows++;
            if (!tmr_out && !prev) dbl++;
            prev = tmr_out;
        end
        check("R6 one low cycle per match", 16'(lows), 16'd10);
        check("R6 no double-length pulse", 16'(dbl), 16'd0);
        check("R5 restart keeps count below ref", 16'(maxc), 16'd4);
        rd(3'd4, v); check("R4 ref flag set", v & 16'h2, 16'h2);
        wr(3'd0, mw(8'd0, 2'd0, 0, 1, 1, 1, 2'd1));
        repeat (3) @(negedge clk);
        flips = 0; prev = tmr_out;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (tmr_out != prev) flips++;
            prev = tmr_out;
        end
        check("R7 toggles once per match", 16'(flips), 16'd10);
        wr(3'd0, 16'h0000);
        wr(3'd4, 16'h0003);
        rd(3'd4, v); check("R9 flags cleared", v, 16'h0000);
        wr(3'd0, mw(8'd0, 2'd0, 0, 0, 0, 1, 2'd1));
        repeat (20) @(negedge clk);
        rd(3'd3, v); check("R5 free run passes ref", v, 16'd20);
        rd(3'd4, v); check("R4 flag in free run", v, 16'h0002);
        wr(3'd0, 16'h0000);
        check("R10 no irq when ref_ie off", {15'd0, irq}, 16'd0);
        wr(3'd0, mw(8'd0, 2'd0, 1, 0, 0, 0, 2'd0));
        check("R10 immediate irq on enable", {15'd0, irq}, 16'd1);
        wr(3'd4, 16'h0002);
        check("R10 irq drops after clear", {15'd0, irq}, 16'd0);
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'hFFFF);
    endtask

    task automatic edge_cap(input string req, input logic lvl);
        logic [15:0] c, v;
        ext_pin = lvl;
        repeat (2) @(negedge clk);
        rd(3'd3, c);
        @(negedge clk);
        rd(3'd2, v); check(req, v, c);
        rd(3'd4, v); check({req, " flag"}, v & 16'h1, 16'h1);
    endtask

    task automatic no_cap(input string req, input logic lvl);
        logic [15:0] c0, v;
        wr(3'd4, 16'h0001);
        rd(3'd2, c0);
        ext_pin = lvl;
        repeat (6) @(negedge clk);
        rd(3'd2, v); check(req, v, c0);
        rd(3'd4, v); check({req, " no flag"}, v & 16'h1, 16'h0);
    endtask

    task automatic t_capture;
        ext_pin = 1'b0;
        wr(3'd1, 16'd3);
        wr(3'd0, mw(8'd0, 2'd1, 0, 0, 0, 1, 2'd1));
        wr(3'd4, 16'h0003);
        repeat (5) @(negedge clk);
        edge_cap("R8 rising capture", 1'b1);
        check("R10 capture irq despite ref_ie off", {15'd0, irq}, 16'd1);
        no_cap("R8 falling ignored in rising mode", 1'b0);
        wr(3'd0, mw(8'd0, 2'd2, 0, 0, 0, 1, 2'd1));
        no_cap("R8 rising ignored in falling mode", 1'b1);
        edge_cap("R8 falling capture", 1'b0);
        wr(3'd0, mw(8'd0, 2'd3, 0, 0, 0, 1, 2'd1));
        edge_cap("R8 both mode rise", 1'b1);
        edge_cap("R8 both mode fall", 1'b0);
        wr(3'd0, mw(8'd0, 2'd0, 0, 0, 0, 1, 2'd1));
        no_cap("R8 capture off", 1'b1);
        check("R10 no irq when cap off", {15'd0, irq}, 16'd0);
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_w1c;
        logic [15:0] v;
        wr(3'd1, 16'd3);
        wr(3'd0, mw(8'd0, 2'd3, 0, 0, 1, 1, 2'd1));
        ext_pin = 1'b1;
        repeat (6) @(negedge clk);
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        wr(3'd0, 16'h0000);
        rd(3'd4, v); check("R9 both flags set", v, 16'h0003);
        wr(3'd4, 16'h0000);
        rd(3'd4, v); check("R9 zero write keeps flags", v, 16'h0003);
        wr(3'd4, 16'h0002);
        rd(3'd4, v); check("R9 clear ref only", v, 16'h0001);
        wr(3'd4, 16'h0001);
        rd(3'd4, v); check("R9 clear capture", v, 16'h0000);
        wr(3'd1, 16'hFFFF);
    endtask

    task automatic pin_pulses(input int n, input int ph);
        for (int i = 0; i < n; i++) begin
            ext_pin = 1'b1;
            repeat (ph) @(negedge clk);
            ext_pin = 1'b0;
            repeat (ph) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_ext_clock;
        logic [15:0] c0, c1;
        ext_pin = 1'b0;
        wr(3'd0, mw(8'd0, 2'd0, 0, 0, 0, 1, 2'd3));
        repeat (4) @(negedge clk);
        rd(3'd3, c0);
        pin_pulses(6, 2);
        rd(3'd3, c1); check("R11 R2 pin falling edges counted", c1 - c0, 16'd6);
        pin_pulses(5, 1);
        rd(3'd3, c0); check("R11 one-cycle phases counted", c0 - c1, 16'd5);
        wr(3'd0, mw(8'd1, 2'd0, 0, 0, 0, 1, 2'd3));
        repeat (4) @(negedge clk);
        rd(3'd3, c0);
        pin_pulses(6, 1);
        rd(3'd3, c1); check("R1 R11 pin with psc 1", c1 - c0, 16'd3);
        wr(3'd0, 16'h0000);
    endtask

    logic done = 1'b0;

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs_while_stopped();
        t_sources();
        t_compare();
        t_capture();
        t_w1c();
        t_ext_clock();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule